// File: doc/BRIEF.md
# Byte ALU with Status Register

This block is the arithmetic core and the processor status byte of a small accumulator-style CPU. Each cycle it computes a result from an operation code and two byte operands: add with carry, subtract with borrow, shifts and rotates of operand A, a bit test, or a plain transfer of operand B. When the update strobe is high, the flags that belong to that operation are written into the status register at the next clock edge. While the decimal flag is set, add and subtract produce packed-BCD results with a decimal carry.

A separate command input sets or clears single flags in the status register, and a command takes priority over the update for the flag it names. The block also decides whether an interrupt is taken. The interrupt-disable flag masks ordinary requests but does not mask a software break. It presents the status image to push on interrupt entry, in which the break bit records whether the entry came from a software break. Fetch, decode and the stack memory are handled by neighbouring logic.

Top module: `byte_alu_core`

## Requirements
- R1: A synchronous active-high reset loads the status byte to 8'h04. The bit positions, from bit 0 to bit 7, are carry, zero, interrupt-disable, decimal, break, memory-mode, overflow and negative.
- R2: op_i selects the operation: 0 add A+B+carry, 1 subtract A-B-(not carry), 2 shift A left, 3 shift A right, 4 rotate A left, 5 rotate A right, 6 bit test with result A AND B, 7 transfer with result B. result_o is combinational from the inputs and the current status.
- R3: On add, carry takes the carry out of bit 7. On subtract, carry is 1 when no borrow occurred and 0 when one did.
- R4: Shift left moves A[7] into carry and shift right moves A[0] into carry; both fill the vacated bit with 0. Rotates fill the vacated bit with the old carry.
- R5: In binary mode, on add, subtract, shifts, rotates and transfer, zero is set exactly when the result is 0 and negative copies result bit 7.
- R6: Overflow is set when a binary signed add or subtract leaves the range -128..+127, and it is cleared otherwise. Shifts, rotates and transfer leave overflow unchanged.
- R7: With the decimal flag set, add and subtract give a packed-BCD result and a decimal carry (1 = carry out on add, 1 = no borrow on subtract). Zero, overflow and negative are unspecified in that case. Shifts, rotates and transfer behave the same in both modes.
- R8: The bit test sets negative to B[7], overflow to B[6] and zero to ((A AND B) == 0), and it leaves carry unchanged.
- R9: fcmd_i codes: 0 none, 1 set carry, 2 clear carry, 3 set interrupt-disable, 4 clear interrupt-disable, 5 set decimal, 6 clear decimal, 7 set memory-mode, 8 clear memory-mode, 9 clear overflow. A command overrides the update for the flag it names.
- R10: With upd_i low and fcmd_i equal to 0, the status byte holds its value whatever op_i, a_i and b_i are.
- R11: irq_take_o is high when brk_req_i is high, or when irq_req_i is high and interrupt-disable is 0.
- R12: stack_img_o equals the status byte except bit 4, which is 1 when brk_req_i is high and 0 otherwise. Bit 4 of status_o always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code |
| a_i | input | 8 | Operand A (shift and rotate source) |
| b_i | input | 8 | Operand B |
| upd_i | input | 1 | Write the operation's flags at the next edge |
| fcmd_i | input | 4 | Single-flag set/clear command |
| irq_req_i | input | 1 | Maskable interrupt request |
| brk_req_i | input | 1 | Software break request |
| result_o | output | 8 | Operation result |
| status_o | output | 8 | Status byte |
| irq_take_o | output | 1 | Interrupt accepted |
| stack_img_o | output | 8 | Status image to push on interrupt entry |

## Verification
The hardest states to reach are those that depend on a carry-in and a mode that were set earlier. Examples are a decimal subtract whose high digit borrows while the low digit does not, and a rotate that must pull in a carry left by an earlier operation. For each vector in the table, the bench first uses flag commands to force the carry and decimal flags to known values, then applies the operation. Decimal and binary runs of the same shift check that the mode has no effect on it. Clashes between a command and an update in the same cycle are driven on purpose, to show that the command wins.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

    localparam int DW = 8;
    localparam int DIGITS = DW / 4;
    localparam logic [DW-1:0] STATUS_RST = 8'h04;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_SHL  = 3'd2,
        OP_SHR  = 3'd3,
        OP_ROL  = 3'd4,
        OP_ROR  = 3'd5,
        OP_TEST = 3'd6,
        OP_MOVE = 3'd7
    } alu_op_e;

    typedef enum logic [3:0] {
        FC_NONE  = 4'd0,
        FC_SET_C = 4'd1,
        FC_CLR_C = 4'd2,
        FC_SET_I = 4'd3,
        FC_CLR_I = 4'd4,
        FC_SET_D = 4'd5,
        FC_CLR_D = 4'd6,
        FC_SET_T = 4'd7,
        FC_CLR_T = 4'd8,
        FC_CLR_V = 4'd9
    } flag_cmd_e;

    // bit 0 is the last member
    typedef struct packed {
        logic n;
        logic v;
        logic t;
        logic b;
        logic d;
        logic i;
        logic z;
        logic c;
    } status_t;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          c;
        logic          z;
        logic          v;
        logic          n;
        logic          wr_c;
        logic          wr_zn;
        logic          wr_v;
    } alu_out_t;

    function automatic logic is_zero(input logic [DW-1:0] x);
        return (x == '0);
    endfunction

endpackage

// File: rtl/byte_alu_arith.sv
module byte_alu_arith
    import byte_alu_pkg::*;
#(
    parameter int WIDTH = DW
) (
    input  logic             sub_i,
    input  logic             dec_i,
    input  logic             cin_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] res_o,
    output logic             c_o,
    output logic             v_o
);
    localparam int ND = WIDTH / 4;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   bin_sum;
    logic [WIDTH-1:0] dec_res;
    logic [ND:0]      dchain;

    // binary path: subtract is A + ~B + carry
    assign b_eff   = sub_i ? ~b_i : b_i;
    assign bin_sum = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin_i};
    assign v_o     = (a_i[WIDTH-1] == b_eff[WIDTH-1]) &&
                     (bin_sum[WIDTH-1] != a_i[WIDTH-1]);

    // decimal path: one corrected digit per nibble, ripple between digits
    assign dchain[0] = cin_i;

    for (genvar k = 0; k < ND; k++) begin : g_digit
        logic [4:0] raw;
        logic [3:0] fix;
        logic       nxt;
        always_comb begin
            if (!sub_i) begin
                raw = {1'b0, a_i[4*k +: 4]} + {1'b0, b_i[4*k +: 4]} +
                      {4'd0, dchain[k]};
                if (raw > 5'd9) begin
                    fix = raw[3:0] + 4'd6;
                    nxt = 1'b1;
                end else begin
                    fix = raw[3:0];
                    nxt = 1'b0;
                end
            end else begin
                raw = {1'b0, a_i[4*k +: 4]} - {1'b0, b_i[4*k +: 4]} -
                      {4'd0, ~dchain[k]};
                if (raw[4]) begin
                    fix = raw[3:0] - 4'd6;
                    nxt = 1'b0;
                end else begin
                    fix = raw[3:0];
                    nxt = 1'b1;
                end
            end
        end
        assign dec_res[4*k +: 4] = fix;
        assign dchain[k+1]       = nxt;
    end

    assign res_o = dec_i ? dec_res    : bin_sum[WIDTH-1:0];
    assign c_o   = dec_i ? dchain[ND] : bin_sum[WIDTH];

endmodule

// File: rtl/byte_alu_shift.sv
module byte_alu_shift
    import byte_alu_pkg::*;
#(
    parameter int WIDTH = DW
) (
    input  logic             left_i,
    input  logic             rot_i,
    input  logic             cin_i,
    input  logic [WIDTH-1:0] a_i,
    output logic [WIDTH-1:0] res_o,
    output logic             c_o
);
    logic fill;

    assign fill = rot_i & cin_i;

    always_comb begin
        if (left_i) begin
            res_o = {a_i[WIDTH-2:0], fill};
            c_o   = a_i[WIDTH-1];
        end else begin
            res_o = {fill, a_i[WIDTH-1:1]};
            c_o   = a_i[0];
        end
    end

endmodule

// File: rtl/byte_alu_status.sv
module byte_alu_status
    import byte_alu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      upd_i,
    input  alu_out_t  alu_i,
    input  flag_cmd_e cmd_i,
    output status_t   st_o
);
    status_t st_q;
    status_t st_d;

    always_comb begin
        st_d = st_q;
        if (upd_i) begin
            if (alu_i.wr_c) st_d.c = alu_i.c;
            if (alu_i.wr_zn) begin
                st_d.z = alu_i.z;
                st_d.n = alu_i.n;
            end
            if (alu_i.wr_v) st_d.v = alu_i.v;
        end
        // a command overrides the update on its own flag
        case (cmd_i)
            FC_SET_C: st_d.c = 1'b1;
            FC_CLR_C: st_d.c = 1'b0;
            FC_SET_I: st_d.i = 1'b1;
            FC_CLR_I: st_d.i = 1'b0;
            FC_SET_D: st_d.d = 1'b1;
            FC_CLR_D: st_d.d = 1'b0;
            FC_SET_T: st_d.t = 1'b1;
            FC_CLR_T: st_d.t = 1'b0;
            FC_CLR_V: st_d.v = 1'b0;
            default:  ;
        endcase
        st_d.b = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= status_t'(STATUS_RST);
        else     st_q <= st_d;
    end

    assign st_o = st_q;

endmodule

// File: rtl/byte_alu_core.sv
module byte_alu_core
    import byte_alu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          upd_i,
    input  logic [3:0]    fcmd_i,
    input  logic          irq_req_i,
    input  logic          brk_req_i,
    output logic [DW-1:0] result_o,
    output logic [DW-1:0] status_o,
    output logic          irq_take_o,
    output logic [DW-1:0] stack_img_o
);
    alu_op_e       op;
    status_t       st;
    status_t       img;
    alu_out_t      alu;
    logic [DW-1:0] ar_res;
    logic          ar_c;
    logic          ar_v;
    logic [DW-1:0] sh_res;
    logic          sh_c;
    logic [DW-1:0] tst_res;

    assign op = alu_op_e'(op_i);

    byte_alu_arith #(.WIDTH(DW)) u_arith (
        .sub_i (op == OP_SUB),
        .dec_i (st.d),
        .cin_i (st.c),
        .a_i   (a_i),
        .b_i   (b_i),
        .res_o (ar_res),
        .c_o   (ar_c),
        .v_o   (ar_v)
    );

    byte_alu_shift #(.WIDTH(DW)) u_shift (
        .left_i (op == OP_SHL || op == OP_ROL),
        .rot_i  (op == OP_ROL || op == OP_ROR),
        .cin_i  (st.c),
        .a_i    (a_i),
        .res_o  (sh_res),
        .c_o    (sh_c)
    );

    assign tst_res = a_i & b_i;

    always_comb begin
        alu = '0;
        unique case (op)
            OP_ADD, OP_SUB: begin
                alu.res   = ar_res;
                alu.c     = ar_c;
                alu.v     = ar_v;
                alu.wr_c  = 1'b1;
                alu.wr_v  = 1'b1;
                alu.wr_zn = 1'b1;
            end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                alu.res   = sh_res;
                alu.c     = sh_c;
                alu.wr_c  = 1'b1;
                alu.wr_zn = 1'b1;
            end
            OP_TEST: begin
                alu.res   = tst_res;
                alu.v     = b_i[DW-2];
                alu.wr_v  = 1'b1;
                alu.wr_zn = 1'b1;
            end
            default: begin
                alu.res   = b_i;
                alu.wr_zn = 1'b1;
            end
        endcase
        alu.z = is_zero(alu.res);
        alu.n = (op == OP_TEST) ? b_i[DW-1] : alu.res[DW-1];
    end

    byte_alu_status u_status (
        .clk   (clk),
        .rst   (rst),
        .upd_i (upd_i),
        .alu_i (alu),
        .cmd_i (flag_cmd_e'(fcmd_i)),
        .st_o  (st)
    );

    always_comb begin
        img   = st;
        img.b = brk_req_i;
    end

    assign result_o    = alu.res;
    assign status_o    = st;
    assign stack_img_o = img;
    assign irq_take_o  = brk_req_i | (irq_req_i & ~st.i);

endmodule

// File: rtl/byte_alu_core_chk.sv
module byte_alu_core_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] op_i,
    input logic [7:0] b_i,
    input logic       upd_i,
    input logic [3:0] fcmd_i,
    input logic       irq_req_i,
    input logic       brk_req_i,
    input logic [7:0] status_o,
    input logic       irq_take_o,
    input logic [7:0] stack_img_o
);
    // R12
    b_bit_zero_chk: assert property (@(posedge clk) disable iff (rst)
        status_o[4] == 1'b0);

    // R12
    brk_img_chk: assert property (@(posedge clk) disable iff (rst)
        brk_req_i |-> stack_img_o[4]);

    // R12
    irq_img_chk: assert property (@(posedge clk) disable iff (rst)
        !brk_req_i |-> (!stack_img_o[4] && stack_img_o[7:5] == status_o[7:5]
                        && stack_img_o[3:0] == status_o[3:0]));

    // R11
    irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req_i && !brk_req_i && status_o[2]) |-> !irq_take_o);

    // R11
    brk_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        brk_req_i |-> irq_take_o);

    // R9
    clr_v_chk: assert property (@(posedge clk) disable iff (rst)
        (fcmd_i == 4'd9) |=> !status_o[6]);

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!upd_i && fcmd_i == 4'd0) |=> $stable(status_o));

    // R8
    test_nv_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_i && op_i == 3'd6 && fcmd_i == 4'd0) |=>
            (status_o[7:6] == $past(b_i[7:6])));

endmodule

bind byte_alu_core byte_alu_core_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .op_i        (op_i),
    .b_i         (b_i),
    .upd_i       (upd_i),
    .fcmd_i      (fcmd_i),
    .irq_req_i   (irq_req_i),
    .brk_req_i   (brk_req_i),
    .status_o    (status_o),
    .irq_take_o  (irq_take_o),
    .stack_img_o (stack_img_o)
);

// File: tb/tb_byte_alu_core.sv
module tb_byte_alu_core;
    import byte_alu_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] op_i = 3'd0;
    logic [7:0] a_i = 8'h00;
    logic [7:0] b_i = 8'h00;
    logic       upd_i = 1'b0;
    logic [3:0] fcmd_i = 4'd0;
    logic       irq_req_i = 1'b0;
    logic       brk_req_i = 1'b0;
    logic [7:0] result_o;
    logic [7:0] status_o;
    logic       irq_take_o;
    logic [7:0] stack_img_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    byte_alu_core dut (
        .clk         (clk),
        .rst         (rst),
        .op_i        (op_i),
        .a_i         (a_i),
        .b_i         (b_i),
        .upd_i       (upd_i),
        .fcmd_i      (fcmd_i),
        .irq_req_i   (irq_req_i),
        .brk_req_i   (brk_req_i),
        .result_o    (result_o),
        .status_o    (status_o),
        .irq_take_o  (irq_take_o),
        .stack_img_o (stack_img_o)
    );

    // flg and msk are ordered {carry, zero, overflow, negative}
    typedef struct packed {
        logic [2:0] op;
        logic [7:0] a;
        logic [7:0] b;
        logic       cin;
        logic       dec;
        logic [7:0] res;
        logic [3:0] flg;
        logic [3:0] msk;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 8'h50, 8'h50, 1'b0, 1'b0, 8'hA0, 4'b0011, 4'b1111}, // R2 R6 overflow add
        '{3'd0, 8'hFF, 8'h01, 1'b0, 1'b0, 8'h00, 4'b1100, 4'b1111}, // R3 R5 carry out, zero
        '{3'd0, 8'h7F, 8'h00, 1'b1, 1'b0, 8'h80, 4'b0011, 4'b1111}, // R3 carry in used
        '{3'd1, 8'h50, 8'hF0, 1'b1, 1'b0, 8'h60, 4'b0000, 4'b1111}, // R3 borrow
        '{3'd1, 8'h50, 8'hB0, 1'b1, 1'b0, 8'hA0, 4'b0011, 4'b1111}, // R6 overflow sub
        '{3'd1, 8'h05, 8'h05, 1'b0, 1'b0, 8'hFF, 4'b0001, 4'b1111}, // R3 borrow in
        '{3'd1, 8'h10, 8'h05, 1'b1, 1'b0, 8'h0B, 4'b1000, 4'b1111}, // R3 no borrow
        '{3'd0, 8'h45, 8'h38, 1'b0, 1'b1, 8'h83, 4'b0000, 4'b1000}, // R7 low digit carry
        '{3'd0, 8'h99, 8'h01, 1'b0, 1'b1, 8'h00, 4'b1000, 4'b1000}, // R7 decimal wrap
        '{3'd0, 8'h58, 8'h46, 1'b1, 1'b1, 8'h05, 4'b1000, 4'b1000}, // R7 carry in
        '{3'd1, 8'h46, 8'h12, 1'b1, 1'b1, 8'h34, 4'b1000, 4'b1000}, // R7 plain sub
        '{3'd1, 8'h40, 8'h13, 1'b1, 1'b1, 8'h27, 4'b1000, 4'b1000}, // R7 low digit borrow
        '{3'd1, 8'h12, 8'h21, 1'b1, 1'b1, 8'h91, 4'b0000, 4'b1000}, // R7 high digit borrow
        '{3'd2, 8'h81, 8'h00, 1'b0, 1'b0, 8'h02, 4'b1000, 4'b1101}, // R4 shift left
        '{3'd2, 8'h81, 8'h00, 1'b0, 1'b1, 8'h02, 4'b1000, 4'b1101}, // R7 mode ignored
        '{3'd3, 8'h01, 8'h00, 1'b1, 1'b0, 8'h00, 4'b1100, 4'b1101}, // R4 R5 shift right
        '{3'd4, 8'h80, 8'h00, 1'b1, 1'b0, 8'h01, 4'b1000, 4'b1101}, // R4 rotate left
        '{3'd5, 8'h01, 8'h00, 1'b1, 1'b0, 8'h80, 4'b1001, 4'b1101}, // R4 rotate right
        '{3'd5, 8'h02, 8'h00, 1'b0, 1'b1, 8'h01, 4'b0000, 4'b1101}, // R4 R7 rotate, decimal
        '{3'd6, 8'h0F, 8'hC0, 1'b0, 1'b0, 8'h00, 4'b0111, 4'b1111}, // R8 test zero
        '{3'd6, 8'hFF, 8'h01, 1'b1, 1'b0, 8'h01, 4'b1000, 4'b1111}, // R8 test nonzero
        '{3'd7, 8'h55, 8'h00, 1'b1, 1'b0, 8'h00, 4'b1100, 4'b1101}, // R5 transfer zero
        '{3'd7, 8'h33, 8'h9C, 1'b0, 1'b1, 8'h9C, 4'b0001, 4'b1101}, // R5 transfer negative
        '{3'd0, 8'h50, 8'h50, 1'b0, 1'b0, 8'hA0, 4'b0011, 4'b1111}, // R6 set overflow
        '{3'd2, 8'h01, 8'h00, 1'b0, 1'b0, 8'h02, 4'b0010, 4'b1111}  // R6 overflow kept
    };

    task automatic check(input logic ok, input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic command(input flag_cmd_e c);
        @(negedge clk);
        fcmd_i = c;
        @(negedge clk);
        fcmd_i = FC_NONE;
    endtask

    task automatic run_vec(input int idx);
        vec_t       v;
        logic [3:0] got;
        v = VECS[idx];
        command(v.cin ? FC_SET_C : FC_CLR_C);
        command(v.dec ? FC_SET_D : FC_CLR_D);
        op_i  = v.op;
        a_i   = v.a;
        b_i   = v.b;
        upd_i = 1'b1;
        #1;
        check(result_o == v.res, "R2 R4 R7 R8", $sformatf("vec %0d result", idx),
              result_o, v.res);
        @(negedge clk);
        upd_i = 1'b0;
        got = {status_o[0], status_o[1], status_o[6], status_o[7]};
        check((got & v.msk) == (v.flg & v.msk), "R3 R4 R5 R6 R7 R8",
              $sformatf("vec %0d flags CZVN", idx), {4'h0, got & v.msk},
              {4'h0, v.flg & v.msk});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog all requirements actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] snap;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset value
        check(status_o == 8'h04, "R1", "reset status", status_o, 8'h04);

        // R11 masked after reset, break bypasses; R12 image bit
        irq_req_i = 1'b1;
        #1;
        check(irq_take_o == 1'b0, "R11", "masked irq", {7'd0, irq_take_o}, 8'h00);
        check(stack_img_o == 8'h04, "R12", "irq image", stack_img_o, 8'h04);
        brk_req_i = 1'b1;
        #1;
        check(irq_take_o == 1'b1, "R11", "break bypass", {7'd0, irq_take_o}, 8'h01);
        check(stack_img_o == 8'h14, "R12", "break image", stack_img_o, 8'h14);
        check(status_o[4] == 1'b0, "R12", "live break bit", status_o, 8'h04);
        brk_req_i = 1'b0;
        command(FC_CLR_I);
        #1;
        check(irq_take_o == 1'b1, "R11", "unmasked irq", {7'd0, irq_take_o}, 8'h01);
        irq_req_i = 1'b0;
        #1;
        check(irq_take_o == 1'b0, "R11", "no request", {7'd0, irq_take_o}, 8'h00);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R9 clear overflow (vector 24 left it set)
        command(FC_CLR_V);
        check(status_o[6] == 1'b0, "R9", "clear overflow", status_o, status_o & 8'hBF);

        // R9 memory-mode set and clear
        command(FC_SET_T);
        check(status_o[5] == 1'b1, "R9", "set mode", status_o, status_o | 8'h20);
        command(FC_CLR_T);
        check(status_o[5] == 1'b0, "R9", "clear mode", status_o, status_o & 8'hDF);

        // R9 command beats update on carry; update still writes zero
        command(FC_CLR_D);
        op_i = 3'd0; a_i = 8'hFF; b_i = 8'h01;
        upd_i = 1'b1; fcmd_i = FC_CLR_C;
        @(negedge clk);
        upd_i = 1'b0; fcmd_i = FC_NONE;
        check(status_o[1:0] == 2'b10, "R9", "command priority",
              {6'd0, status_o[1:0]}, 8'h02);

        // R10 no update, no command: status holds
        snap = status_o;
        op_i = 3'd1; a_i = 8'h00; b_i = 8'h80;
        repeat (2) @(negedge clk);
        check(status_o == snap, "R10", "hold", status_o, snap);

        // R1 reset mid-run
        command(FC_SET_D);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(status_o == 8'h04, "R1", "reset again", status_o, 8'h04);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule